// File: doc/BRIEF.md
# Readout Request Gating Sequencer

This block is the single master of a daisy-chained digitizer readout bus. It sits between the wired-OR request line that all front-end converters drive and the readout driver that walks the read-enable token down the chain. The raw request line can droop or spike while modules hand the token on. The driver would then drop and re-raise its read enable in the middle of an event and corrupt a header word. To prevent this, the block looks at the request line only once per event, after a programmable conversion-settling time. If the request was present, it drives a latched, glitch-free request toward the driver until the last module in the chain reports end of readout.

Each event runs as a fixed sequence. A gate edge closes the front-end enable, which acts as a veto on further gates. A settling delay then runs, counted in 8-cycle steps. The request is sampled once. If it was active, the latched request is held until end of readout; if it was inactive, readout is skipped. In both cases a one-cycle clear pulse goes to all modules. A second delay, counted in single-cycle steps, follows before the enable is raised again.

A timeout watches the readout phase. It records whether the stall happened while the downstream write strobe was asserted (a host-side stall) or not (a broken chain). A synchronous command returns the sequencer to idle and clears both flags. In slave configuration the sequencer stays idle and drives neither the request nor the clear.

Top module: `rdreq_gate_seq`

## Requirements
- R1: After reset, req_out, busy, fe_clr, err_vme and err_bus are 0 and fe_enable is 1.
- R2: In idle and master mode (slave_mode = 0), a rising edge on gate with inhibit low is accepted, and fe_enable reads 0 from the next cycle. With inhibit high, a gate edge is not accepted and fe_enable stays 1.
- R3: The request input is sampled exactly settle_code*8 + 1 cycles after the accepting clock edge. If it is 1, req_out and busy rise at that edge.
- R4: Once latched, req_out stays 1 whatever req_in does, until eor, clr_cmd or slave_mode.
- R5: If the sampled request is 0, no request is raised, and fe_clr is high for exactly one cycle, starting at the sampling edge.
- R6: eor = 1 during readout drops req_out and busy at the next edge, and fe_clr is high for exactly that one following cycle.
- R7: fe_enable returns to 1 exactly recover_code + 2 cycles after the cycle in which fe_clr went high.
- R8: Gate edges that arrive while the sequencer is not idle are ignored. Neither the request timing nor fe_enable changes.
- R9: If eor does not arrive within TMO_CYCLES cycles of req_out rising, an error flag is set at that edge. The flag is err_vme if wst was 1 in the last cycle of the window, and err_bus otherwise. The flag is sticky, and req_out stays latched.
- R10: clr_cmd returns the sequencer to idle at the next edge: req_out low, fe_enable high, both error flags cleared.
- R11: With slave_mode = 1, gates are ignored, req_out and fe_clr stay 0, and fe_enable stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock (one cycle = 50 ns step) |
| rst_n | input | 1 | Active-low synchronous reset |
| clr_cmd | input | 1 | Return-to-idle command, also clears error flags |
| slave_mode | input | 1 | 0 = master (sequencing active), 1 = slave (idle) |
| inhibit | input | 1 | Blocks gate acceptance while high |
| gate | input | 1 | Event gate, rising edge starts an event |
| req_in | input | 1 | Wired-OR request from the front-end modules |
| eor | input | 1 | End of readout from the last module's pass output |
| wst | input | 1 | Downstream write strobe, used for timeout classification |
| settle_code | input | CODE_W | Settling delay in SUB_TICK-cycle steps |
| recover_code | input | CODE_W | Post-clear delay in single-cycle steps |
| req_out | output | 1 | Latched request to the readout driver |
| busy | output | 1 | Readout in progress |
| fe_clr | output | 1 | One-cycle clear pulse to front-end modules |
| fe_enable | output | 1 | Front-end enable; low acts as gate veto |
| err_vme | output | 1 | Timeout with write strobe asserted |
| err_bus | output | 1 | Timeout with write strobe idle |

## Verification
The bench builds the sequencer with TMO_CYCLES set to 300 and leaves the step size and code widths at their defaults. The shorter timeout makes both error classifications, their stickiness and the recovery command reachable in a few hundred cycles. Settle codes of 0, 1 and 2 and recover codes of 0 and 5 cover both the zero-length delay path and multi-step counting. Together they pin the exact sampling and re-enable edges against the step arithmetic.

// File: rtl/rdreq_pkg.sv
package rdreq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_READ,
    ST_CLEAR,
    ST_RECOVER
  } seq_st_t;

  // Length of a delay in clock cycles: code value times step size.
  function automatic logic [31:0] dly_cycles(input logic [31:0] code,
                                             input int unsigned step);
    return code * step;
  endfunction

endpackage

// File: rtl/rdreq_delay.sv
module rdreq_delay #(
  parameter int unsigned VW   = 8,
  parameter int unsigned STEP = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          abort,
  input  logic [VW-1:0] code,
  output logic          done
);
  localparam int unsigned CW = VW + $clog2(STEP);

  logic [CW-1:0] cnt;
  logic          run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      run_q <= 1'b0;
    end else if (abort) begin
      cnt   <= '0;
      run_q <= 1'b0;
    end else if (start) begin
      cnt   <= CW'(rdreq_pkg::dly_cycles(32'(code), STEP));
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt == '0) run_q <= 1'b0;
      else           cnt   <= cnt - 1'b1;
    end
  end

  // Expiry event: visible for one cycle once the loaded count has drained.
  assign done = run_q && (cnt == '0);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> !done);  // R3

endmodule

// File: rtl/rdreq_tmo.sv
module rdreq_tmo #(
  parameter int unsigned LIMIT = 65536
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic in_rd,
  input  logic eor,
  input  logic wst,
  output logic err_vme,
  output logic err_bus,
  output logic tmo_fire
);
  localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !in_rd) cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign tmo_fire = in_rd && (cnt == LAST) && !eor && !clr && !err_vme && !err_bus;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      err_vme <= 1'b0;
      err_bus <= 1'b0;
    end else if (tmo_fire) begin
      err_vme <= wst;
      err_bus <= !wst;
    end
  end

  AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_vme && err_bus));  // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_vme || err_bus) && !clr |=> (err_vme || err_bus));  // R9
  AST_CLR_WIPES_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !err_vme && !err_bus);  // R10

endmodule

// File: rtl/rdreq_gate_seq.sv
module rdreq_gate_seq #(
  parameter int unsigned CODE_W     = 8,
  parameter int unsigned SUB_TICK   = 8,
  parameter int unsigned TMO_CYCLES = 65536
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_cmd,
  input  logic              slave_mode,
  input  logic              inhibit,
  input  logic              gate,
  input  logic              req_in,
  input  logic              eor,
  input  logic              wst,
  input  logic [CODE_W-1:0] settle_code,
  input  logic [CODE_W-1:0] recover_code,
  output logic              req_out,
  output logic              busy,
  output logic              fe_clr,
  output logic              fe_enable,
  output logic              err_vme,
  output logic              err_bus
);
  import rdreq_pkg::*;

  seq_st_t st, st_nx;
  logic    gate_q;

  // Named internal events
  logic gate_accept;
  logic settle_done;
  logic rec_done;
  logic sample_hit;
  logic sample_miss;
  logic seq_abort;
  logic tmo_fire;

  assign seq_abort   = clr_cmd || slave_mode;
  assign gate_accept = gate && !gate_q && (st == ST_IDLE) && !inhibit && !seq_abort;
  assign sample_hit  = settle_done && req_in;
  assign sample_miss = settle_done && !req_in;

  always_ff @(posedge clk) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate;
  end

  rdreq_delay #(.VW(CODE_W), .STEP(SUB_TICK)) settle_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (gate_accept),
    .abort (seq_abort),
    .code  (settle_code),
    .done  (settle_done)
  );

  rdreq_delay #(.VW(CODE_W), .STEP(1)) recover_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (st == ST_CLEAR && !seq_abort),
    .abort (seq_abort),
    .code  (recover_code),
    .done  (rec_done)
  );

  rdreq_tmo #(.LIMIT(TMO_CYCLES)) tmo_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr_cmd),
    .in_rd    (st == ST_READ),
    .eor      (eor),
    .wst      (wst),
    .err_vme  (err_vme),
    .err_bus  (err_bus),
    .tmo_fire (tmo_fire)
  );

  always_comb begin
    st_nx = st;
    if (seq_abort) begin
      st_nx = ST_IDLE;
    end else begin
      unique case (st)
        ST_IDLE:    if (gate_accept) st_nx = ST_SETTLE;
        ST_SETTLE:  if (sample_hit) st_nx = ST_READ;
                    else if (sample_miss) st_nx = ST_CLEAR;
        ST_READ:    if (eor) st_nx = ST_CLEAR;
        ST_CLEAR:   st_nx = ST_RECOVER;
        ST_RECOVER: if (rec_done) st_nx = ST_IDLE;
        default:    st_nx = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nx;
  end

  assign req_out   = (st == ST_READ);
  assign busy      = (st == ST_READ);
  assign fe_clr    = (st == ST_CLEAR);
  assign fe_enable = (st == ST_IDLE);

  AST_ACCEPT_VETO: assert property (@(posedge clk) disable iff (!rst_n)
    gate_accept |=> !fe_enable);  // R2
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    req_out && !eor && !seq_abort |=> req_out);  // R4
  AST_MISS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    sample_miss && !seq_abort |=> fe_clr && !req_out);  // R5
  AST_CLR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    fe_clr |=> !fe_clr);  // R5
  AST_EOR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    req_out && eor && !seq_abort |=> fe_clr && !req_out && !busy);  // R6
  AST_TMO_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_fire |=> req_out || seq_abort);  // R9
  AST_CMD_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_cmd |=> fe_enable && !req_out);  // R10
  AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    slave_mode |=> !req_out && !fe_clr && fe_enable);  // R11

endmodule

// File: tb/rdreq_gate_seq_tb.sv
module rdreq_gate_seq_tb_top;
  localparam int unsigned TMO = 300;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr_cmd = 1'b0;
  logic       slave_mode = 1'b0;
  logic       inhibit = 1'b0;
  logic       gate = 1'b0;
  logic       req_in = 1'b0;
  logic       eor = 1'b0;
  logic       wst = 1'b0;
  logic [7:0] settle_code = 8'd0;
  logic [7:0] recover_code = 8'd0;
  logic       req_out, busy, fe_clr, fe_enable, err_vme, err_bus;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  rdreq_gate_seq #(.CODE_W(8), .SUB_TICK(8), .TMO_CYCLES(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .clr_cmd(clr_cmd), .slave_mode(slave_mode),
    .inhibit(inhibit), .gate(gate), .req_in(req_in), .eor(eor), .wst(wst),
    .settle_code(settle_code), .recover_code(recover_code),
    .req_out(req_out), .busy(busy), .fe_clr(fe_clr), .fe_enable(fe_enable),
    .err_vme(err_vme), .err_bus(err_bus)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic gate_pulse();
    gate = 1'b1;
    step();
    gate = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "req_out", req_out, 0);
    chk("R1", "busy", busy, 0);
    chk("R1", "fe_clr", fe_clr, 0);
    chk("R1", "fe_enable", fe_enable, 1);
    chk("R1", "err_vme", err_vme, 0);
    chk("R1", "err_bus", err_bus, 0);
  endtask

  task automatic t_readout(input int d, input int m);
    settle_code = 8'(d);
    recover_code = 8'(m);
    req_in = 1'b1;
    gate_pulse();
    chk("R2", "fe_enable after gate", fe_enable, 0);
    repeat (d * 8) step();
    chk("R3", "req_out before sample", req_out, 0);
    step();
    chk("R3", "req_out at sample", req_out, 1);
    chk("R3", "busy at sample", busy, 1);
    for (int i = 0; i < 6; i++) begin
      req_in = i[0];
      gate = i[1];
      step();
    end
    gate = 1'b0;
    req_in = 1'b0;
    chk("R4", "req_out held through glitches", req_out, 1);
    chk("R8", "fe_enable during readout", fe_enable, 0);
    chk("R8", "fe_clr during readout", fe_clr, 0);
    eor = 1'b1;
    step();
    eor = 1'b0;
    chk("R6", "req_out after eor", req_out, 0);
    chk("R6", "busy after eor", busy, 0);
    chk("R6", "fe_clr after eor", fe_clr, 1);
    step();
    chk("R6", "fe_clr one cycle", fe_clr, 0);
    repeat (m) step();
    chk("R7", "fe_enable before recovery end", fe_enable, 0);
    step();
    chk("R7", "fe_enable after recovery", fe_enable, 1);
  endtask

  task automatic t_skip(input int d, input int m);
    settle_code = 8'(d);
    recover_code = 8'(m);
    req_in = 1'b0;
    gate_pulse();
    repeat (d * 8) step();
    chk("R5", "fe_clr before sample", fe_clr, 0);
    step();
    chk("R5", "fe_clr on empty sample", fe_clr, 1);
    chk("R5", "no request on empty sample", req_out, 0);
    step();
    chk("R5", "fe_clr one cycle", fe_clr, 0);
    repeat (m) step();
    chk("R7", "fe_enable before recovery end", fe_enable, 0);
    step();
    chk("R7", "fe_enable after skip recovery", fe_enable, 1);
  endtask

  task automatic t_regate();
    settle_code = 8'd2;
    recover_code = 8'd0;
    req_in = 1'b1;
    gate_pulse();
    repeat (5) step();
    gate_pulse();
    repeat (16 - 6) step();
    chk("R8", "req_out not restarted (before)", req_out, 0);
    step();
    chk("R8", "req_out at original sample", req_out, 1);
    eor = 1'b1;
    step();
    eor = 1'b0;
    repeat (2) step();
    chk("R8", "idle after re-gated event", fe_enable, 1);
    req_in = 1'b0;
  endtask

  task automatic t_inhibit();
    inhibit = 1'b1;
    settle_code = 8'd0;
    req_in = 1'b1;
    gate_pulse();
    repeat (3) step();
    chk("R2", "fe_enable with inhibit", fe_enable, 1);
    chk("R2", "req_out with inhibit", req_out, 0);
    chk("R2", "fe_clr with inhibit", fe_clr, 0);
    inhibit = 1'b0;
    req_in = 1'b0;
    step();
  endtask

  task automatic t_timeout(input logic w);
    settle_code = 8'd0;
    req_in = 1'b1;
    wst = w;
    gate_pulse();
    step();
    chk("R9", "req_out at start", req_out, 1);
    req_in = 1'b0;
    repeat (TMO - 1) step();
    chk("R9", "no flag before window end", 32'(err_vme | err_bus), 0);
    step();
    chk("R9", "err_vme", err_vme, 32'(w));
    chk("R9", "err_bus", err_bus, 32'(!w));
    chk("R9", "req_out held at timeout", req_out, 1);
    wst = 1'b0;
    repeat (4) step();
    chk("R9", "flag sticky", 32'(err_vme | err_bus), 1);
    clr_cmd = 1'b1;
    step();
    clr_cmd = 1'b0;
    chk("R10", "flags cleared", 32'(err_vme | err_bus), 0);
    chk("R10", "req_out dropped", req_out, 0);
    chk("R10", "fe_enable restored", fe_enable, 1);
    step();
  endtask

  task automatic t_slave();
    slave_mode = 1'b1;
    settle_code = 8'd0;
    req_in = 1'b1;
    step();
    gate_pulse();
    for (int i = 0; i < 4; i++) begin
      step();
      chk("R11", "req_out in slave", req_out, 0);
      chk("R11", "fe_enable in slave", fe_enable, 1);
      chk("R11", "fe_clr in slave", fe_clr, 0);
    end
    slave_mode = 1'b0;
    req_in = 1'b0;
    step();
  endtask

  initial begin
    repeat (4) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_readout(0, 0);
    t_readout(1, 5);
    t_readout(2, 0);
    t_skip(0, 5);
    t_skip(1, 0);
    t_regate();
    t_inhibit();
    t_timeout(1'b1);
    t_timeout(1'b0);
    t_slave();
    t_readout(0, 5);
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule